// File: doc/BRIEF.md
# Shadow Memory Attribute Router

This block sits in the path of CPU memory accesses to the legacy upper-memory window of a PC-style system, the 256 KB span from 0xC0000 to 0xFFFFF. It keeps seven byte-wide attribute registers. Together they split the window into sixteen 16 KB segments. The four topmost segments form one 64 KB BIOS region with a single shared attribute. For each access that falls inside the window, the block picks one of three outcomes from the segment's attribute: send the access to shadow RAM, send it to the underlying ROM, or drop it.

Firmware programs the attributes through a byte-wide configuration port that is indexed by register number. The read-enable and write-enable bits act on their own. This lets a region be read from ROM while writes to it land in shadow RAM, which is the normal way to copy BIOS code down into RAM. The RAM and ROM arrays are outside the block. Each is reached through its own select/acknowledge handshake. The CPU side uses a word address with byte enables, and each access is a request pulse answered by a one-cycle acknowledge.

An access is handled by a four-state machine:
- ST_IDLE waits for a request.
- ST_RAM holds the shadow RAM select until the RAM acknowledges.
- ST_ROM holds the ROM select until the ROM acknowledges.
- ST_RESP returns the acknowledge and the read data to the CPU.

The transitions are:
- ACCEPT_RAM, IDLE to RAM: a read with read enable set, or a write with write enable set.
- ACCEPT_ROM, IDLE to ROM: a read with read enable clear.
- ACCEPT_LOCAL, IDLE to RESP: a write with write enable clear, or any access outside the window.
- RAM_DONE, RAM to RESP: the RAM acknowledges.
- ROM_DONE, ROM to RESP: the ROM acknowledges.
- RETIRE, RESP to IDLE: always, after one cycle.

Top module: `shadow_attr_router`

## Requirements
- R1: After reset, every attribute register (indices 0x59 to 0x5F) reads back 0x00, and reads anywhere in the window are served by the ROM.
- R2: A configuration write to an index from 0x59 to 0x5F stores the whole byte, reserved and cache bits included, and a read of that index returns it. Indices outside that range read 0x00, and writes to them change no register.
- R3: Each attribute nibble uses bit 0 as read enable, bit 1 as write enable, bit 2 as cache enable and bit 3 as reserved. Index 0x5A+k (k = 0..5) controls 16 KB segment 2k with its low nibble and segment 2k+1 with its high nibble. Segment n starts at byte address 0xC0000 + n*0x4000. The high nibble of index 0x59 controls the single region 0xF0000 to 0xFFFFF (segments 12 to 15).
- R4: A read in a segment with read enable set asserts only the shadow RAM select and returns the shadow RAM word at the same window offset.
- R5: A read in a segment with read enable clear asserts only the ROM select and returns the ROM word at the same window offset (word address within the window, bits 15:0).
- R6: A write in a segment with write enable set reaches shadow RAM with its byte enables passed through, so only the enabled bytes change. A write with write enable clear asserts no select, is still acknowledged, and leaves the memory unchanged.
- R7: Read enable and write enable act independently. With read enable clear and write enable set, writes land in shadow RAM while reads still come from ROM.
- R8: An access outside 0xC0000 to 0xFFFFF asserts neither select, is acknowledged, and returns zero read data.
- R9: An attribute change applies from the first CPU request accepted after the configuration write cycle. A request accepted in the same cycle as the write uses the old value.
- R10: The shadow RAM select and the ROM select are never both high. A select stays high until its acknowledge arrives, and the CPU acknowledge follows one cycle later as a single-cycle pulse.
- R11: The cache bit and the reserved low nibble of index 0x59 have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_idx (combinational) |
| cpu_req | input | 1 | CPU access request pulse, taken in ST_IDLE |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_waddr | input | 18 | CPU word address (byte address bits 19:2) |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_ack is high |
| cpu_ack | output | 1 | One-cycle access completion |
| ram_sel | output | 1 | Shadow RAM select |
| ram_we | output | 1 | Shadow RAM write |
| ram_addr | output | 16 | Word offset within the window |
| ram_be | output | 4 | Shadow RAM byte enables |
| ram_wdata | output | 32 | Shadow RAM write data |
| ram_rdata | input | 32 | Shadow RAM read data |
| ram_ack | input | 1 | Shadow RAM acknowledge |
| rom_sel | output | 1 | ROM select (reads only) |
| rom_addr | output | 16 | Word offset within the window |
| rom_rdata | input | 32 | ROM read data |
| rom_ack | input | 1 | ROM acknowledge |

## Verification
A configuration write and the acceptance of a CPU request can fall in the same clock cycle. The bench forces this by driving cfg_we and cpu_req on the same edge. One case changes a segment's read enable from clear to set. The access accepted in that cycle must still be served by the ROM, with only rom_sel seen high, and the next access must come from shadow RAM. The sweep covers every segment under all four read/write enable combinations. For each case the bench compares the data returned, and which select was raised, against a RAM image and a ROM formula that the bench keeps itself.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Access sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAM  = 2'd1,
        ST_ROM  = 2'd2,
        ST_RESP = 2'd3
    } sar_state_e;

    // Bit positions inside one attribute nibble
    localparam int unsigned ATTR_RD_BIT = 0;
    localparam int unsigned ATTR_WR_BIT = 1;

    // Index of the first attribute register on the configuration port
    localparam logic [7:0] SAR_CFG_BASE = 8'h59;

endpackage

// File: rtl/sar_attr_regs.sv
module sar_attr_regs
    import sar_pkg::*;
#(
    parameter int unsigned NUM_REG = 7,
    parameter int unsigned NUM_SEG = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_idx,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic [NUM_SEG-1:0] seg_rd_en,
    output logic [NUM_SEG-1:0] seg_wr_en
);

    // segments paired under registers 1..NUM_REG-1, the rest share register 0
    localparam int unsigned PAIRED_SEG = 2 * (NUM_REG - 1);

    logic [7:0] attr_q [NUM_REG];
    logic [NUM_REG-1:0] hit;

    genvar r;
    generate
        for (r = 0; r < NUM_REG; r++) begin : g_reg
            assign hit[r] = (cfg_idx == SAR_CFG_BASE + 8'(r));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    attr_q[r] <= 8'h00;
                end else if (cfg_we && hit[r]) begin
                    attr_q[r] <= cfg_wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        cfg_rdata = 8'h00;
        for (int i = 0; i < NUM_REG; i++) begin
            if (hit[i]) begin
                cfg_rdata = attr_q[i];
            end
        end
    end

    genvar s;
    generate
        for (s = 0; s < NUM_SEG; s++) begin : g_seg
            if (s < PAIRED_SEG) begin : g_pair
                localparam int unsigned REG = 1 + s / 2;
                localparam int unsigned NIB = 4 * (s % 2);
                assign seg_rd_en[s] = attr_q[REG][NIB + ATTR_RD_BIT];
                assign seg_wr_en[s] = attr_q[REG][NIB + ATTR_WR_BIT];
            end else begin : g_top
                assign seg_rd_en[s] = attr_q[0][4 + ATTR_RD_BIT];
                assign seg_wr_en[s] = attr_q[0][4 + ATTR_WR_BIT];
            end
        end
    endgenerate

endmodule

// File: rtl/sar_region_decode.sv
module sar_region_decode #(
    parameter int unsigned WORD_AW = 18,
    parameter int unsigned SEG_WAW = 12,
    parameter int unsigned NUM_SEG = 16
) (
    input  logic [WORD_AW-1:0] waddr,
    input  logic [NUM_SEG-1:0] seg_rd_en,
    input  logic [NUM_SEG-1:0] seg_wr_en,
    output logic               in_win,
    output logic               rd_en,
    output logic               wr_en
);

    localparam int unsigned WIN_WAW = WORD_AW - 2;
    localparam int unsigned SEG_IW  = WIN_WAW - SEG_WAW;

    logic [SEG_IW-1:0] seg;

    // window is the topmost quarter of the address space
    assign in_win = &waddr[WORD_AW-1:WIN_WAW];
    assign seg    = waddr[WIN_WAW-1:SEG_WAW];
    assign rd_en  = seg_rd_en[seg];
    assign wr_en  = seg_wr_en[seg];

endmodule

// File: rtl/sar_access_fsm.sv
module sar_access_fsm
    import sar_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned WIN_WAW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [WIN_WAW-1:0]  cpu_off,
    input  logic [DATA_W/8-1:0] cpu_be,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic                in_win,
    input  logic                rd_en,
    input  logic                wr_en,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_ack,
    output logic                ram_sel,
    output logic                ram_we,
    output logic [WIN_WAW-1:0]  ram_addr,
    output logic [DATA_W/8-1:0] ram_be,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    input  logic                ram_ack,
    output logic                rom_sel,
    output logic [WIN_WAW-1:0]  rom_addr,
    input  logic [DATA_W-1:0]   rom_rdata,
    input  logic                rom_ack
);

    sar_state_e state_q, state_d;

    logic [WIN_WAW-1:0]  off_q;
    logic                we_q;
    logic [DATA_W/8-1:0] be_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (!in_win)
                        state_d = ST_RESP;            // ACCEPT_LOCAL
                    else if (cpu_we)
                        state_d = wr_en ? ST_RAM      // ACCEPT_RAM
                                        : ST_RESP;    // ACCEPT_LOCAL
                    else
                        state_d = rd_en ? ST_RAM      // ACCEPT_RAM
                                        : ST_ROM;     // ACCEPT_ROM
                end
            end
            ST_RAM:  if (ram_ack) state_d = ST_RESP;  // RAM_DONE
            ST_ROM:  if (rom_ack) state_d = ST_RESP;  // ROM_DONE
            ST_RESP: state_d = ST_IDLE;               // RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and read data return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q   <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        off_q   <= cpu_off;
                        we_q    <= cpu_we;
                        be_q    <= cpu_be;
                        wdata_q <= cpu_wdata;
                        rdata_q <= '0;
                    end
                end
                ST_RAM:  if (ram_ack) rdata_q <= we_q ? '0 : ram_rdata;
                ST_ROM:  if (rom_ack) rdata_q <= rom_rdata;
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        ram_sel = 1'b0;
        rom_sel = 1'b0;
        cpu_ack = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RAM:  ram_sel = 1'b1;
            ST_ROM:  rom_sel = 1'b1;
            ST_RESP: cpu_ack = 1'b1;
            default: ;
        endcase
    end

    assign ram_we    = we_q;
    assign ram_addr  = off_q;
    assign ram_be    = be_q;
    assign ram_wdata = wdata_q;
    assign rom_addr  = off_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/shadow_attr_router.sv
module shadow_attr_router
    import sar_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned WORD_AW = 18,
    parameter int unsigned SEG_WAW = 12,
    parameter int unsigned NUM_REG = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_idx,
    input  logic [7:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [WORD_AW-1:0]  cpu_waddr,
    input  logic [DATA_W/8-1:0] cpu_be,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_ack,
    output logic                ram_sel,
    output logic                ram_we,
    output logic [WORD_AW-3:0]  ram_addr,
    output logic [DATA_W/8-1:0] ram_be,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    input  logic                ram_ack,
    output logic                rom_sel,
    output logic [WORD_AW-3:0]  rom_addr,
    input  logic [DATA_W-1:0]   rom_rdata,
    input  logic                rom_ack
);

    localparam int unsigned WIN_WAW = WORD_AW - 2;
    localparam int unsigned NUM_SEG = 1 << (WIN_WAW - SEG_WAW);

    logic [NUM_SEG-1:0] seg_rd_en;
    logic [NUM_SEG-1:0] seg_wr_en;
    logic               in_win;
    logic               rd_en;
    logic               wr_en;

    sar_attr_regs #(
        .NUM_REG (NUM_REG),
        .NUM_SEG (NUM_SEG)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .seg_rd_en (seg_rd_en),
        .seg_wr_en (seg_wr_en)
    );

    sar_region_decode #(
        .WORD_AW (WORD_AW),
        .SEG_WAW (SEG_WAW),
        .NUM_SEG (NUM_SEG)
    ) u_dec (
        .waddr     (cpu_waddr),
        .seg_rd_en (seg_rd_en),
        .seg_wr_en (seg_wr_en),
        .in_win    (in_win),
        .rd_en     (rd_en),
        .wr_en     (wr_en)
    );

    sar_access_fsm #(
        .DATA_W  (DATA_W),
        .WIN_WAW (WIN_WAW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_off   (cpu_waddr[WIN_WAW-1:0]),
        .cpu_be    (cpu_be),
        .cpu_wdata (cpu_wdata),
        .in_win    (in_win),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .cpu_rdata (cpu_rdata),
        .cpu_ack   (cpu_ack),
        .ram_sel   (ram_sel),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_be    (ram_be),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .ram_ack   (ram_ack),
        .rom_sel   (rom_sel),
        .rom_addr  (rom_addr),
        .rom_rdata (rom_rdata),
        .rom_ack   (rom_ack)
    );

endmodule

// File: rtl/sar_checker.sv
module sar_checker (
    input logic clk,
    input logic rst_n,
    input logic ram_sel,
    input logic ram_ack,
    input logic rom_sel,
    input logic rom_ack,
    input logic cpu_ack
);

    p_excl_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_sel && rom_sel));

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    p_ram_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel && !ram_ack) |=> ram_sel);

    p_rom_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && !rom_ack) |=> rom_sel);

    p_ram_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel && ram_ack) |=> (cpu_ack && !ram_sel));

    p_rom_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && rom_ack) |=> (cpu_ack && !rom_sel));

endmodule

bind shadow_attr_router sar_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ram_sel (ram_sel),
    .ram_ack (ram_ack),
    .rom_sel (rom_sel),
    .rom_ack (rom_ack),
    .cpu_ack (cpu_ack)
);

// File: tb/tb_shadow_attr_router.sv
`timescale 1ns/1ps
module tb_shadow_attr_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_idx = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [17:0] cpu_waddr = '0;
    logic [3:0]  cpu_be = 4'h0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack;
    logic        ram_sel, ram_we, rom_sel;
    logic [15:0] ram_addr, rom_addr;
    logic [3:0]  ram_be;
    logic [31:0] ram_wdata, ram_rdata, rom_rdata;
    logic        ram_ack = 1'b0;
    logic        rom_ack = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    shadow_attr_router dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_waddr(cpu_waddr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .ram_sel(ram_sel), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .ram_ack(ram_ack),
        .rom_sel(rom_sel), .rom_addr(rom_addr), .rom_rdata(rom_rdata), .rom_ack(rom_ack)
    );

    // memory models: shadow RAM keeps 16 words per segment
    logic [31:0] ram_mem [256];
    logic [31:0] exp_mem [256];

    function automatic int midx(input logic [15:0] off);
        return {24'd0, off[15:12], off[3:0]};
    endfunction

    function automatic logic [31:0] rom_word(input logic [15:0] off);
        return 32'hC0DE_0000 ^ {16'h0, off} ^ {off, 16'h0};
    endfunction

    assign ram_rdata = ram_mem[midx(ram_addr)];
    assign rom_rdata = rom_word(rom_addr);

    always @(posedge clk) begin
        if (ram_sel && !ram_ack) begin
            ram_ack <= 1'b1;
            if (ram_we) begin
                for (int b = 0; b < 4; b++)
                    if (ram_be[b]) ram_mem[midx(ram_addr)][8*b +: 8] <= ram_wdata[8*b +: 8];
            end
        end else begin
            ram_ack <= 1'b0;
        end
        rom_ack <= rom_sel && !rom_ack;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] idx, output logic [7:0] val);
        @(negedge clk);
        cfg_idx = idx;
        #1 val = cfg_rdata;
    endtask

    // one CPU access; reports which selects were seen
    task automatic access(input bit we, input logic [19:0] baddr, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output bit saw_ram, output bit saw_rom);
        int wait_n;
        saw_ram = 0; saw_rom = 0; rd = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_waddr = baddr[19:2]; cpu_be = be; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        wait_n = 0;
        while (!cpu_ack && wait_n < 20) begin
            if (ram_sel) saw_ram = 1;
            if (rom_sel) saw_rom = 1;
            @(negedge clk);
            wait_n++;
        end
        check(cpu_ack, "R10 ack timeout", {31'd0, cpu_ack}, 32'd1);
        rd = cpu_rdata;
    endtask

    function automatic logic [7:0] reg_of(input int seg);
        return (seg >= 12) ? 8'h59 : 8'(8'h5A + seg / 2);
    endfunction

    function automatic int nib_of(input int seg);
        return (seg >= 12) ? 1 : seg % 2;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0]  v;
        logic [31:0] rd;
        bit sr, so;

        for (int i = 0; i < 256; i++) begin
            ram_mem[i] = 32'h5A00_0000 | i;
            exp_mem[i] = 32'h5A00_0000 | i;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and ROM routing
        for (int r = 8'h59; r <= 8'h5F; r++) begin
            cfg_read(8'(r), v);
            check(v == 8'h00, "R1 reset attr", {24'd0, v}, 32'd0);
        end
        access(0, 20'hC0008, 4'hF, 0, rd, sr, so);
        check(so && !sr && rd == rom_word(16'h0002), "R1 reset read seg0", rd, rom_word(16'h0002));
        access(0, 20'hFC004, 4'hF, 0, rd, sr, so);
        check(so && !sr && rd == rom_word(16'hF001), "R1 reset read F region", rd, rom_word(16'hF001));

        // R2: readback of full byte and out-of-range indices
        cfg_write(8'h5C, 8'hF7);
        cfg_read(8'h5C, v);
        check(v == 8'hF7, "R2 readback", {24'd0, v}, 32'hF7);
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_read(8'h58, v);
        check(v == 8'h00, "R2 index 0x58 reads zero", {24'd0, v}, 32'd0);
        cfg_read(8'h59, v);
        check(v == 8'h00, "R2 neighbour 0x59 untouched", {24'd0, v}, 32'd0);
        cfg_read(8'h5F, v);
        check(v == 8'h00, "R2 neighbour 0x5F untouched", {24'd0, v}, 32'd0);
        cfg_write(8'h5C, 8'h00);

        // R3 R4 R5 R6 R7 R11: sweep every segment under every enable pair
        for (int seg = 0; seg < 16; seg++) begin
            for (int c = 0; c < 4; c++) begin
                logic [3:0]  nib;
                logic [7:0]  rv;
                logic [15:0] off;
                logic [19:0] ba;
                logic [31:0] pat, exp;
                bit re, wen;
                re  = c[0];
                wen = c[1];
                nib = 4'(c) | ((c == 3) ? 4'h4 : 4'h0);  // cache bit must not matter (R11)
                if (seg >= 12)
                    rv = {nib, 4'hB};                     // reserved low nibble junk (R11)
                else
                    rv = (nib_of(seg) == 1) ? {nib, 4'h0} : {4'h0, nib};
                cfg_write(reg_of(seg), rv);
                off = 16'(seg * 4096 + c + 4 * (seg % 3));
                ba  = {2'b11, off, 2'b00};
                pat = {8'(seg), 8'(c), 16'hA55A};
                access(1, ba, 4'hF, pat, rd, sr, so);
                check(sr == wen && !so, "R6 R3 write routing", {30'd0, sr, so}, {30'd0, wen, 1'b0});
                if (wen) exp_mem[midx(off)] = pat;
                access(0, ba, 4'hF, 0, rd, sr, so);
                exp = re ? exp_mem[midx(off)] : rom_word(off);
                check(rd == exp, re ? "R4 R3 RAM read data" : "R5 R7 ROM read data", rd, exp);
                check(sr == re && so == !re, "R4 R5 read select", {30'd0, sr, so}, {30'd0, re, !re});
                cfg_write(reg_of(seg), 8'h00);
            end
        end

        // R6: partial write with byte enables
        cfg_write(8'h5B, 8'h03);
        access(1, 20'hC8004, 4'b0101, 32'h1122_3344, rd, sr, so);
        exp_mem[midx(16'h2001)][7:0]   = 8'h44;
        exp_mem[midx(16'h2001)][23:16] = 8'h22;
        access(0, 20'hC8004, 4'hF, 0, rd, sr, so);
        check(rd == exp_mem[midx(16'h2001)], "R6 byte enables", rd, exp_mem[midx(16'h2001)]);
        cfg_write(8'h5B, 8'h00);

        // R8: outside the window
        access(0, 20'hA0010, 4'hF, 0, rd, sr, so);
        check(!sr && !so && rd == 0, "R8 outside read", rd, 32'd0);
        access(1, 20'h00040, 4'hF, 32'hDEAD_BEEF, rd, sr, so);
        check(!sr && !so, "R8 outside write no select", {30'd0, sr, so}, 32'd0);

        // R9: config write and request accepted in the same cycle
        cfg_write(8'h5E, 8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 8'h5E; cfg_wdata = 8'h01;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_waddr = 18'h38000; cpu_be = 4'hF;
        @(negedge clk);
        cfg_we = 1'b0; cpu_req = 1'b0;
        sr = 0; so = 0;
        for (int k = 0; k < 20 && !cpu_ack; k++) begin
            if (ram_sel) sr = 1;
            if (rom_sel) so = 1;
            @(negedge clk);
        end
        check(cpu_ack && so && !sr && cpu_rdata == rom_word(16'h8000), "R9 same-cycle uses old",
              cpu_rdata, rom_word(16'h8000));
        access(0, 20'hE0000, 4'hF, 0, rd, sr, so);
        check(sr && !so && rd == exp_mem[midx(16'h8000)], "R9 next access uses new",
              rd, exp_mem[midx(16'h8000)]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule